// File: doc/BRIEF.md
# Shared Address/Data Register Port

This block is the slave side of a byte-wide register port on which one 8-bit bus carries both the register address and the register data. The host first presents an address and pulses an address strobe. The address is captured when the strobe falls. The host then pulls chip select low together with either the read strobe or the write strobe. On a read, the block drives the contents of the selected register onto the bus. On a write, it takes the byte the host holds on the bus and stores it when the access ends.

All host signals, including the bus itself, pass through a two-stage synchronizer into the core clock, and every edge is detected on the synchronized copies. The bus is modelled as a separate input, output and output-enable, so that a pad or a top-level tri-state can be built around it. Each read access also produces a one-cycle pulse that carries the latched address, so that registers elsewhere that clear when read can react to it.

Addresses below `NUM_REGS` (8 by default) are mapped. Any other address reads as zero and ignores writes.

Top module: `regbus_slave`

## Requirements
- R1: After a synchronous reset, `bus_oe` is 0, `bus_out` is 0x00, `rd_pulse` is 0, and every mapped register reads back as 0x00.
- R2: The address is captured from `bus_in` only when `ale` falls from 1 to 0. Later bus activity leaves it unchanged, so several accesses may follow one address phase.
- R3: While `cs_n` and `rd_n` are both held low, after the synchronizer latency, `bus_oe` is 1 and `bus_out` equals the register at the latched address. An address at or above `NUM_REGS` reads as 0x00.
- R4: Whenever `cs_n` and `rd_n` are not both low, after the synchronizer latency, `bus_oe` is 0 and `bus_out` is 0x00.
- R5: A write is stored when `wr_n` returns high while `cs_n` is still low. The stored value is the byte held on `bus_in` during the strobe.
- R6: A write is equally stored when `cs_n` returns high while `wr_n` is still low.
- R7: A write access in which `cs_n` and `wr_n` are both low for fewer than `MIN_WR_CYCLES` core cycles (3 by default) stores nothing. An access of exactly `MIN_WR_CYCLES` cycles stores its data.
- R8: A write to an address at or above `NUM_REGS` changes no register.
- R9: Each read access raises `rd_pulse` for exactly one cycle, with `rd_pulse_addr` equal to the latched address. Write accesses raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; the address is taken on its falling edge |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Value seen on the shared address/data bus |
| bus_out | output | 8 | Read data for the shared bus; 0x00 while not driving |
| bus_oe | output | 1 | High while the block drives the shared bus |
| rd_pulse | output | 1 | One-cycle pulse at the start of each read access |
| rd_pulse_addr | output | 8 | Latched address that accompanies `rd_pulse` |

## Verification
The hardest case to reach from the ports is a write whose strobe overlap is right at the minimum width. Either strobe can end that overlap, and the outcome differs by a single cycle. The stimulus therefore issues writes with overlaps of two and three core cycles, ended in turn by `wr_n` and by `cs_n`. Each write is followed by a read-back, which exposes whether the data was stored. A cycle-by-cycle model in the bench tracks the stable host strobes and compares `bus_oe` and `bus_out` on every clock. Separate counts of `rd_pulse` show that write accesses never raise the read pulse.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

    localparam int BUS_W = 8;

    typedef logic [BUS_W-1:0] byte_t;

    // Host control lines as seen after synchronization
    typedef struct packed {
        logic ale;
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    // Idle level of the host lines: address strobe low, active-low strobes high
    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};

    function automatic logic addr_mapped(byte_t a, int unsigned nregs);
        return (32'(a) < nregs);
    endfunction

endpackage

// File: rtl/regbus_sync.sv
module regbus_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/regbus_ctrl.sv
module regbus_ctrl
    import regbus_pkg::*;
#(
    parameter int MIN_WR_CYCLES = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb,
    input  byte_t   bus_s,
    output byte_t   addr_q,
    output byte_t   wdata_q,
    output logic    wr_commit,
    output logic    rd_active,
    output logic    rd_pulse
);

    localparam int CNT_W = $clog2(MIN_WR_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_WR_CYCLES);

    logic             ale_prev;
    logic             wr_prev;
    logic             rd_prev;
    logic             wr_active;
    logic             ale_fall;
    logic [CNT_W-1:0] wr_len;

    assign wr_active = !stb.cs_n && !stb.wr_n;
    assign rd_active = !stb.cs_n && !stb.rd_n;
    assign ale_fall  = ale_prev && !stb.ale;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_prev <= 1'b0;
            wr_prev  <= 1'b0;
            rd_prev  <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            wr_len   <= '0;
        end else begin
            ale_prev <= stb.ale;
            wr_prev  <= wr_active;
            rd_prev  <= rd_active;
            if (ale_fall) addr_q <= bus_s;
            if (wr_active) begin
                wdata_q <= bus_s;
                if (wr_len != CNT_MAX) wr_len <= wr_len + 1'b1;
            end else begin
                wr_len <= '0;
            end
        end
    end

    // End of a write access: either strobe released, pulse long enough
    assign wr_commit = wr_prev && !wr_active && (wr_len == CNT_MAX);
    assign rd_pulse  = rd_active && !rd_prev;

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ale_fall |=> $stable(addr_q)) else $error("address moved without strobe"); // R2

    AST_RD_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |=> !rd_pulse) else $error("read pulse longer than one cycle"); // R9

endmodule

// File: rtl/regbus_regfile.sv
module regbus_regfile
    import regbus_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  byte_t waddr,
    input  byte_t wdata,
    input  byte_t raddr,
    output byte_t rdata
);

    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    byte_t                   regs [NUM_REGS];
    logic [NUM_REGS*BUS_W-1:0] regs_flat;
    logic [IDX_W-1:0]        ridx;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) regs[i] <= '0;
                else if (we && (32'(waddr) == i)) regs[i] <= wdata;
            end
            assign regs_flat[i*BUS_W +: BUS_W] = regs[i];
        end
    endgenerate

    assign ridx  = raddr[IDX_W-1:0];
    assign rdata = addr_mapped(raddr, NUM_REGS) ? regs[ridx] : '0;

    AST_UNMAPPED_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && !addr_mapped(waddr, NUM_REGS)) |=> $stable(regs_flat)) else $error("unmapped write changed a register"); // R8

endmodule

// File: rtl/regbus_slave.sv
module regbus_slave
    import regbus_pkg::*;
#(
    parameter int NUM_REGS      = 8,
    parameter int MIN_WR_CYCLES = 3,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ale,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] bus_in,
    output logic [7:0] bus_out,
    output logic       bus_oe,
    output logic       rd_pulse,
    output logic [7:0] rd_pulse_addr
);

    localparam int SYNC_W = BUS_W + STROBE_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{BUS_W{1'b0}}, STROBE_IDLE};

    strobe_t            stb_raw;
    strobe_t            stb_s;
    byte_t              bus_s;
    logic [SYNC_W-1:0]  sync_q;

    byte_t addr_q;
    byte_t wdata_q;
    byte_t rdata;
    logic  wr_commit;
    logic  rd_active;
    logic  rd_pulse_i;
    byte_t bus_out_q;
    logic  bus_oe_q;

    assign stb_raw = '{ale: ale, cs_n: cs_n, rd_n: rd_n, wr_n: wr_n};

    // Bus value and strobes share one pipeline so they stay aligned
    regbus_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({bus_in, stb_raw}),
        .q   (sync_q)
    );

    assign stb_s = strobe_t'(sync_q[STROBE_W-1:0]);
    assign bus_s = sync_q[SYNC_W-1:STROBE_W];

    regbus_ctrl #(
        .MIN_WR_CYCLES (MIN_WR_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .stb       (stb_s),
        .bus_s     (bus_s),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wr_commit (wr_commit),
        .rd_active (rd_active),
        .rd_pulse  (rd_pulse_i)
    );

    regbus_regfile #(
        .NUM_REGS (NUM_REGS)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_commit),
        .waddr (addr_q),
        .wdata (wdata_q),
        .raddr (addr_q),
        .rdata (rdata)
    );

    // Registered bus turnaround: data is forced to zero whenever not driving
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_oe_q  <= 1'b0;
            bus_out_q <= '0;
        end else begin
            bus_oe_q  <= rd_active;
            bus_out_q <= rd_active ? rdata : '0;
        end
    end

    assign bus_out       = bus_out_q;
    assign bus_oe        = bus_oe_q;
    assign rd_pulse      = rd_pulse_i;
    assign rd_pulse_addr = addr_q;

    AST_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_out == '0)) else $error("data on bus while released"); // R4

    AST_PULSE_THEN_DRIVE: assert property (@(posedge clk) disable iff (rst)
        rd_pulse |=> bus_oe) else $error("read pulse without bus drive"); // R9

endmodule

// File: tb/test_regbus_slave.sv
module test_regbus_slave;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       rd_pulse;
    logic [7:0] rd_pulse_addr;

    int tests = 0;
    int fails = 0;
    bit ready = 1'b0;
    bit done  = 1'b0;

    // Behavioural reference state
    logic [7:0] mreg [8];
    int         maddr = 0;
    int         npulse = 0;
    logic [7:0] last_paddr = 8'h00;
    logic [3:0] prev_lines = 4'b0111;
    int         stab = 0;

    always #10 clk = ~clk;

    regbus_slave i_regbus_slave (
        .clk           (clk),
        .rst           (rst),
        .ale           (ale),
        .cs_n          (cs_n),
        .rd_n          (rd_n),
        .wr_n          (wr_n),
        .bus_in        (bus_in),
        .bus_out       (bus_out),
        .bus_oe        (bus_oe),
        .rd_pulse      (rd_pulse),
        .rd_pulse_addr (rd_pulse_addr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(int a);
        return (a < 8) ? mreg[a] : 8'h00;
    endfunction

    // Per-clock comparison, sampled mid high phase
    always @(posedge clk) begin
        #5;
        if (ready && !done) begin
            if (rd_pulse) begin
                npulse++;
                last_paddr = rd_pulse_addr;
            end
            if ({ale, cs_n, rd_n, wr_n} == prev_lines) stab++;
            else stab = 0;
            prev_lines = {ale, cs_n, rd_n, wr_n};
            if (stab >= 3) begin
                if (!cs_n && !rd_n) begin
                    chk("R3 oe", {7'd0, bus_oe}, 8'h01);
                    chk("R3 data", bus_out, model_read(maddr));
                end else begin
                    chk("R4 oe", {7'd0, bus_oe}, 8'h00);
                    chk("R4 data", bus_out, 8'h00);
                end
            end
        end
    end

    task automatic set_addr(input logic [7:0] a);
        @(negedge clk);
        bus_in = a;
        ale = 1'b1;
        repeat (3) @(negedge clk);
        ale = 1'b0;
        repeat (3) @(negedge clk);
        bus_in = 8'hC3;
        repeat (2) @(negedge clk);
        maddr = a;
    endtask

    task automatic do_write(input logic [7:0] d, input int n, input bit cs_first);
        int p0;
        p0 = npulse;
        @(negedge clk);
        bus_in = d;
        cs_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b0;
        repeat (n) @(negedge clk);
        if (cs_first) cs_n = 1'b1;
        else          wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        wr_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_in = 8'h3C ^ d;
        if (n >= 3 && maddr < 8) mreg[maddr] = d;
        chk("R9 no pulse on write", 8'(npulse - p0), 8'd0);
    endtask

    task automatic do_read(input string tag);
        int p0;
        p0 = npulse;
        @(negedge clk);
        cs_n = 1'b0;
        rd_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(tag, bus_out, model_read(maddr));
        chk({tag, " oe"}, {7'd0, bus_oe}, 8'h01);
        cs_n = 1'b1;
        rd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9 pulse count", 8'(npulse - p0), 8'd1);
        chk("R9 pulse addr", last_paddr, 8'(maddr));
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mreg[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        ready = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        chk("R1 oe", {7'd0, bus_oe}, 8'h00);
        chk("R1 data", bus_out, 8'h00);
        chk("R1 pulse", {7'd0, rd_pulse}, 8'h00);
        for (int a = 0; a < 8; a++) begin
            set_addr(8'(a));
            do_read("R1 reg cleared");
        end

        // R5: write ended by the write strobe
        set_addr(8'd3);
        do_write(8'hA5, 4, 1'b0);
        do_read("R5 readback");

        // R6: write ended by chip select
        set_addr(8'd5);
        do_write(8'h3C, 5, 1'b1);
        do_read("R6 readback");

        // R7: too short, both release orders, then exactly minimum
        set_addr(8'd3);
        do_write(8'hFF, 2, 1'b0);
        do_read("R7 short wr kept old");
        do_write(8'h11, 2, 1'b1);
        do_read("R7 short cs kept old");
        set_addr(8'd6);
        do_write(8'h77, 3, 1'b0);
        do_read("R7 minimum stored");
        set_addr(8'd7);
        do_write(8'h81, 3, 1'b1);
        do_read("R7 minimum via cs");

        // R8: unmapped write ignored, unmapped read is zero
        set_addr(8'h20);
        do_write(8'hEE, 4, 1'b0);
        do_read("R3 unmapped read");
        set_addr(8'h08);
        do_write(8'hDD, 4, 1'b1);
        do_read("R3 unmapped edge");
        for (int a = 0; a < 8; a++) begin
            set_addr(8'(a));
            do_read("R8 mapped untouched");
        end

        // R2: address survives bus traffic; repeated accesses on one latch
        set_addr(8'd2);
        do_write(8'h00, 4, 1'b0);
        do_write(8'h5A, 4, 1'b0);
        do_read("R2 held addr first");
        do_read("R2 held addr second");
        do_write(8'hC7, 6, 1'b1);
        do_read("R2 held addr after write");

        // R5: assorted data patterns
        set_addr(8'd0);
        do_write(8'hFF, 4, 1'b0);
        do_read("R5 all ones");
        set_addr(8'd1);
        do_write(8'h01, 4, 1'b1);
        do_read("R5 single bit");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule